// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block sequences the drive waveforms of a multiplexed liquid-crystal panel with four common lines and a parameterised number of segment lines (80 by default). It counts oscillator ticks into frames of 24 ticks each and splits each frame into one to four equal common slots, depending on the duty strap. The inverting polarity of alternate frames keeps the net DC on the glass at zero. For every common and segment line it outputs a 2-bit level code, and an external analog stage turns each code into a voltage. Each segment line reads its on/off bit from the display row of the slot that is active.

In a cascade, one chip is the master. It produces a clock divided by 16 from its tick and a frame-sync pulse. Slave chips realign their frame phase on each rising edge of the sync line, and they hold their common outputs at ground. The frame phase is a two-state machine. `PH_POS` moves to `PH_NEG` at a frame end, and `PH_NEG` moves back to `PH_POS` at a frame end. A slave sync edge forces `PH_POS` from either state.

Top module: `lcd_wave_seq`

## Requirements
- R1: After reset the frame counter and tick divider are 0 and the phase is positive. With `disp_en`=1 and master mode, slot 0 is active, `cko`=0 and `sync_out`=1.
- R2: A frame lasts 24 `osc_tick` pulses. The phase inverts at every frame end. In positive phase a selected common is code 11 (full); in negative phase it is code 00.
- R3: With `duty_sel`=11 the frame holds four slots of 6 ticks each, in the order 0,1,2,3. Slot s spans frame counts from s*24/N up to (s+1)*24/N-1, where N = `duty_sel`+1.
- R4: The duty folding is as follows. 00 selects all four commons in the single slot. 01 selects commons 0 and 2 in slot 0 and commons 1 and 3 in slot 1. 10 selects common 0 in slot 0, commons 1 and 3 in slot 1, and common 2 in slot 2.
- R5: With `bias_half`=0 in positive phase, an unselected common is code 01, an on segment is 00 and an off segment is 10. In negative phase an unselected common is 10, an on segment is 11 and an off segment is 01.
- R6: With `bias_half`=1, an unselected common and an off segment are both code 01 in either phase. The selected common and an on segment keep the full/ground codes of R2 and R5.
- R7: Segment j reads bit j of row s, where s is the active slot. A change of `row_bits` appears on the segment outputs in the same cycle.
- R8: In master mode `cko` toggles after every 8 ticks (period 16 ticks). In slave mode `cko` is 0.
- R9: In master mode `sync_out` is 1 exactly while the frame counter is 0 in positive phase. In slave mode it is 0.
- R10: In slave mode a rising edge on `sync_in` sets the frame counter to 0 and the phase to positive on the next clock edge.
- R11: In slave mode (`is_master`=0) every common output is code 00.
- R12: With `disp_en`=0 every common and segment output is code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| duty_sel | input | 2 | Duty strap: 00 static, 01 half, 10 third, 11 quarter |
| bias_half | input | 1 | 1 selects half bias, 0 selects third bias |
| is_master | input | 1 | 1 for master, 0 for slave |
| sync_in | input | 1 | Frame-sync input used in slave mode |
| disp_en | input | 1 | Display enable; 0 blanks all outputs |
| row_bits | input | 4 x NSEG | Segment on/off bits, one row per common slot |
| sync_out | output | 1 | Frame-sync output in master mode |
| cko | output | 1 | Tick divided by 16 in master mode |
| com_lvl | output | 4 x 2 | Level code per common line |
| seg_lvl | output | NSEG x 2 | Level code per segment line |

## Verification
Full frames are stepped under each duty strap, and every tick's outputs are compared with a model. This separates the slot length and the slot order from the folding of commons. The same sweeps repeat under both bias straps and in both phases, so that the off-level codes of the two bias modes are kept apart. The slave runs start with a sync edge part-way through a frame, which shows whether realignment and the common hold work. Random row patterns, together with random strap and enable changes, show whether each segment reads its bit from the row of the active slot.

// File: rtl/lcd_wave_pkg.sv
package lcd_wave_pkg;

    localparam int NCOM   = 4;
    localparam int SLOT_W = 2;

    typedef enum logic [1:0] {
        LV_GND   = 2'b00,
        LV_THIRD = 2'b01,
        LV_TWO3  = 2'b10,
        LV_FULL  = 2'b11
    } lvl_t;

    typedef enum logic {
        PH_POS = 1'b0,
        PH_NEG = 1'b1
    } phase_t;

    // number of common slots per frame for a duty strap value
    function automatic logic [2:0] slot_count(input logic [1:0] duty);
        return 3'(duty) + 3'd1;
    endfunction

    // slot in which common k is selected, after folding
    function automatic logic [SLOT_W-1:0] com_slot(input logic [1:0] duty,
                                                   input logic [SLOT_W-1:0] k);
        logic [SLOT_W-1:0] s;
        case (duty)
            2'b00:   s = '0;
            2'b01:   s = {1'b0, k[0]};
            2'b10:   s = (k == 2'd3) ? 2'd1 : k;
            default: s = k;
        endcase
        return s;
    endfunction

    function automatic lvl_t com_code(input logic sel, input logic neg, input logic half);
        lvl_t c;
        if (sel)       c = neg ? LV_GND : LV_FULL;
        else if (half) c = LV_THIRD;
        else           c = neg ? LV_TWO3 : LV_THIRD;
        return c;
    endfunction

    function automatic lvl_t seg_code(input logic on, input logic neg, input logic half);
        lvl_t c;
        if (on)        c = neg ? LV_FULL : LV_GND;
        else if (half) c = LV_THIRD;
        else           c = neg ? LV_THIRD : LV_TWO3;
        return c;
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_wave_pkg::*;
#(
    parameter int FRAME_TICKS = 24,
    parameter int CKO_DIV     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          osc_tick,
    input  logic                          is_master,
    input  logic                          sync_in,
    input  logic [1:0]                    duty_sel,
    output logic [$clog2(FRAME_TICKS)-1:0] fcnt,
    output logic [SLOT_W-1:0]             slot,
    output logic                          neg,
    output logic                          sync_rise,
    output logic                          sync_out,
    output logic                          cko
);

    localparam int FW     = $clog2(FRAME_TICKS);
    localparam int HALF   = CKO_DIV / 2;
    localparam int DW     = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [FW-1:0] F_LAST = FW'(FRAME_TICKS - 1);
    localparam logic [DW-1:0] D_LAST = DW'(HALF - 1);

    phase_t          phase_q, phase_d;
    logic [FW-1:0]   fcnt_q, fcnt_d;
    logic            sync_q;
    logic [DW-1:0]   dcnt_q;
    logic            ck_q;
    logic            frame_end;

    assign sync_rise = !is_master && sync_in && !sync_q;
    assign frame_end = osc_tick && (fcnt_q == F_LAST);

    // phase state machine and frame counter: register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_POS;
            fcnt_q  <= '0;
            sync_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            fcnt_q  <= fcnt_d;
            sync_q  <= sync_in;
        end
    end

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        fcnt_d  = fcnt_q;
        if (sync_rise) begin
            phase_d = PH_POS;
            fcnt_d  = '0;
        end else if (osc_tick) begin
            if (frame_end) begin
                fcnt_d = '0;
                unique case (phase_q)
                    PH_POS: phase_d = PH_NEG;
                    PH_NEG: phase_d = PH_POS;
                endcase
            end else begin
                fcnt_d = fcnt_q + 1'b1;
            end
        end
    end

    // free-running tick divider for the cascade clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt_q <= '0;
            ck_q   <= 1'b0;
        end else if (osc_tick) begin
            if (dcnt_q == D_LAST) begin
                dcnt_q <= '0;
                ck_q   <= ~ck_q;
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    // output process
    always_comb begin
        int prod;
        prod     = int'(fcnt_q) * int'(slot_count(duty_sel));
        slot     = SLOT_W'(prod / FRAME_TICKS);
        fcnt     = fcnt_q;
        neg      = (phase_q == PH_NEG);
        sync_out = is_master && (phase_q == PH_POS) && (fcnt_q == '0);
        cko      = is_master && ck_q;
    end

endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
    import lcd_wave_pkg::*;
(
    input  logic [1:0]            duty_sel,
    input  logic [SLOT_W-1:0]     slot,
    input  logic                  neg,
    input  logic                  bias_half,
    input  logic                  en,
    output logic [NCOM-1:0][1:0]  com_lvl
);

    for (genvar k = 0; k < NCOM; k++) begin : g_com
        logic sel;
        assign sel = (com_slot(duty_sel, SLOT_W'(k)) == slot);
        assign com_lvl[k] = en ? com_code(sel, neg, bias_half) : LV_GND;
    end

endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
    import lcd_wave_pkg::*;
#(
    parameter int NSEG = 80
) (
    input  logic [NCOM-1:0][NSEG-1:0] row_bits,
    input  logic [SLOT_W-1:0]         slot,
    input  logic                      neg,
    input  logic                      bias_half,
    input  logic                      en,
    output logic [NSEG-1:0][1:0]      seg_lvl
);

    logic [NSEG-1:0] cur_row;
    assign cur_row = row_bits[slot];

    for (genvar j = 0; j < NSEG; j++) begin : g_seg
        assign seg_lvl[j] = en ? seg_code(cur_row[j], neg, bias_half) : LV_GND;
    end

endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
    import lcd_wave_pkg::*;
#(
    parameter int NSEG        = 80,
    parameter int FRAME_TICKS = 24,
    parameter int CKO_DIV     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      osc_tick,
    input  logic [1:0]                duty_sel,
    input  logic                      bias_half,
    input  logic                      is_master,
    input  logic                      sync_in,
    input  logic                      disp_en,
    input  logic [NCOM-1:0][NSEG-1:0] row_bits,
    output logic                      sync_out,
    output logic                      cko,
    output logic [NCOM-1:0][1:0]      com_lvl,
    output logic [NSEG-1:0][1:0]      seg_lvl
);

    localparam int FW = $clog2(FRAME_TICKS);

    logic [FW-1:0]     fcnt_w;
    logic [SLOT_W-1:0] slot_w;
    logic              neg_w;
    logic              sync_rise_w;

    lcd_frame_timer #(
        .FRAME_TICKS (FRAME_TICKS),
        .CKO_DIV     (CKO_DIV)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .is_master (is_master),
        .sync_in   (sync_in),
        .duty_sel  (duty_sel),
        .fcnt      (fcnt_w),
        .slot      (slot_w),
        .neg       (neg_w),
        .sync_rise (sync_rise_w),
        .sync_out  (sync_out),
        .cko       (cko)
    );

    lcd_com_drive u_com (
        .duty_sel  (duty_sel),
        .slot      (slot_w),
        .neg       (neg_w),
        .bias_half (bias_half),
        .en        (disp_en && is_master),
        .com_lvl   (com_lvl)
    );

    lcd_seg_drive #(
        .NSEG (NSEG)
    ) u_seg (
        .row_bits  (row_bits),
        .slot      (slot_w),
        .neg       (neg_w),
        .bias_half (bias_half),
        .en        (disp_en),
        .seg_lvl   (seg_lvl)
    );

endmodule

// File: rtl/lcd_wave_chk.sv
module lcd_wave_chk #(
    parameter int NSEG        = 80,
    parameter int FRAME_TICKS = 24
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           osc_tick,
    input logic                           is_master,
    input logic                           disp_en,
    input logic                           cko,
    input logic [3:0][1:0]                com_lvl,
    input logic [NSEG-1:0][1:0]           seg_lvl,
    input logic [$clog2(FRAME_TICKS)-1:0] fcnt_w,
    input logic                           neg_w,
    input logic                           sync_rise_w
);

    localparam int FW = $clog2(FRAME_TICKS);
    localparam logic [FW-1:0] F_LAST = FW'(FRAME_TICKS - 1);

    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && fcnt_w == F_LAST && !sync_rise_w) |=> (neg_w != $past(neg_w))); // R2

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick && !sync_rise_w) |=> $stable(fcnt_w)); // R3

    AST_CKO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !cko); // R8

    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise_w |=> (fcnt_w == '0 && !neg_w)); // R10

    AST_SLAVE_COM: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (com_lvl == '0)); // R11

    AST_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (com_lvl == '0 && seg_lvl == '0)); // R12

endmodule

bind lcd_wave_seq lcd_wave_chk #(
    .NSEG        (NSEG),
    .FRAME_TICKS (FRAME_TICKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_tick    (osc_tick),
    .is_master   (is_master),
    .disp_en     (disp_en),
    .cko         (cko),
    .com_lvl     (com_lvl),
    .seg_lvl     (seg_lvl),
    .fcnt_w      (fcnt_w),
    .neg_w       (neg_w),
    .sync_rise_w (sync_rise_w)
);

// File: tb/sim_lcd_wave_seq.sv
module sim_lcd_wave_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NSEG       = 80;
    localparam int FT         = 24;
    localparam int CD         = 16;
    localparam int FOLD [4][4] = '{'{0,0,0,0}, '{0,1,0,1}, '{0,1,2,1}, '{0,1,2,3}};

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  osc_tick = 1'b0;
    logic [1:0]            duty_sel = 2'b11;
    logic                  bias_half = 1'b0;
    logic                  is_master = 1'b1;
    logic                  sync_in = 1'b0;
    logic                  disp_en = 1'b1;
    logic [3:0][NSEG-1:0]  row_bits = '0;
    logic                  sync_out, cko;
    logic [3:0][1:0]       com_lvl;
    logic [NSEG-1:0][1:0]  seg_lvl;

    lcd_wave_seq #(.NSEG(NSEG), .FRAME_TICKS(FT), .CKO_DIV(CD)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .duty_sel(duty_sel),
        .bias_half(bias_half), .is_master(is_master), .sync_in(sync_in),
        .disp_en(disp_en), .row_bits(row_bits), .sync_out(sync_out),
        .cko(cko), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0, n_fail = 0;
    int m_fcnt = 0, m_neg = 0, m_ticks = 0;
    bit done = 1'b0;

    function automatic logic [1:0] exp_com(bit sel, int neg, bit half);
        if (sel)  return (neg != 0) ? 2'b00 : 2'b11;
        if (half) return 2'b01;
        return (neg != 0) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [1:0] exp_seg(bit on, int neg, bit half);
        if (on)   return (neg != 0) ? 2'b11 : 2'b00;
        if (half) return 2'b01;
        return (neg != 0) ? 2'b01 : 2'b10;
    endfunction

    task automatic chk(string req, string what, logic [2*NSEG-1:0] act, logic [2*NSEG-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        logic [3:0][1:0]      ec;
        logic [NSEG-1:0][1:0] es;
        int n, slot;
        n    = int'(duty_sel) + 1;
        slot = (m_fcnt * n) / FT;
        for (int k = 0; k < 4; k++)
            ec[k] = (disp_en && is_master) ? exp_com(FOLD[duty_sel][k] == slot, m_neg, bias_half) : 2'b00;
        for (int j = 0; j < NSEG; j++)
            es[j] = disp_en ? exp_seg(row_bits[slot][j], m_neg, bias_half) : 2'b00;
        chk(req, "com_lvl", {152'b0, com_lvl}, {152'b0, ec});
        chk(req, "seg_lvl", seg_lvl, es);
        chk(req, "cko", {159'b0, cko}, {159'b0, is_master && (((m_ticks / (CD/2)) % 2) == 1)});
        chk(req, "sync_out", {159'b0, sync_out}, {159'b0, is_master && m_neg == 0 && m_fcnt == 0});
    endtask

    task automatic do_tick(string req);
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
        m_ticks++;
        if (m_fcnt == FT - 1) begin
            m_fcnt = 0;
            m_neg  = 1 - m_neg;
        end else begin
            m_fcnt++;
        end
        check_all(req);
    endtask

    task automatic do_sync();
        @(negedge clk) sync_in = 1'b1;
        @(negedge clk);
        if (!is_master) begin
            m_fcnt = 0;
            m_neg  = 0;
        end
        check_all("R10");
        sync_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic new_rows();
        for (int c = 0; c < 4; c++)
            for (int j = 0; j < NSEG; j++)
                row_bits[c][j] = 1'($urandom % 2);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h1cd5eed));
        new_rows();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R12: blanking
        disp_en = 1'b0;
        @(negedge clk) check_all("R12");
        repeat (5) do_tick("R12");
        disp_en = 1'b1;

        // R2: static duty, two frames, phase inversion
        duty_sel = 2'b00;
        repeat (2 * FT) do_tick("R2");

        // R4 / R3 / R5: each multiplexed duty over a full frame, third bias
        for (int d = 1; d < 4; d++) begin
            duty_sel = 2'(d);
            repeat (FT) do_tick((d == 3) ? "R3" : "R4");
        end
        repeat (FT) do_tick("R5");

        // R6: half bias in two duties
        bias_half = 1'b1;
        repeat (FT) do_tick("R6");
        duty_sel = 2'b01;
        repeat (FT) do_tick("R6");
        bias_half = 1'b0;

        // R7: row change without a tick
        duty_sel = 2'b11;
        @(negedge clk) new_rows();
        @(negedge clk) check_all("R7");

        // R8 / R9: divider and sync in master mode
        repeat (FT + 3) do_tick("R8");
        while (!(m_fcnt == 0 && m_neg == 0)) do_tick("R9");
        check_all("R9");

        // R11 / R10: slave mode with realignment mid-frame
        is_master = 1'b0;
        repeat (7) do_tick("R11");
        do_sync();
        repeat (FT + 5) do_tick("R10");
        is_master = 1'b1;
        repeat (3) do_tick("R9");

        // random phase
        for (int it = 0; it < 300; it++) begin
            if ($urandom % 5 == 0) duty_sel  = 2'($urandom % 4);
            if ($urandom % 7 == 0) bias_half = 1'($urandom % 2);
            if ($urandom % 9 == 0) disp_en   = ($urandom % 4) != 0;
            if ($urandom % 11 == 0) is_master = ($urandom % 3) != 0;
            if ($urandom % 3 == 0) new_rows();
            if (!is_master && $urandom % 13 == 0) do_sync();
            repeat (1 + $urandom % 4) do_tick("R7");
        end

        done = 1'b1;
        summary();
    end

endmodule